// File: doc/BRIEF.md
# Time-of-Day Event Counter with Read Snapshot

This block is a 24-bit event counter placed inside a peripheral interface device. Software reaches it over a byte-wide register bus as three count byte registers, a control register and an interrupt status register. An external tick input advances the count. The tick is synchronised into the clock domain, and each rising edge adds one while the counter runs.

Software reads the count one byte at a time. A snapshot mechanism keeps the three bytes consistent with one another. Reading the most significant byte freezes a copy of the whole count, and reading the least significant byte releases that copy. Writes follow a matching pattern. Writing the top byte halts counting and writing the bottom byte restarts it, so software can load a new value without a carry running through it partway.

A control bit steers count-byte writes into an alarm register. A match between the live count and the alarm sets a flag that drives an interrupt line. The flag holds until software reads the status register.

Top module: `tod_counter`

## Requirements
- R1: After reset the count is 0, the alarm register is all ones, the alarm flag is 0 and the snapshot is released. The count ignores ticks until the first write to address 0, 1, 2 or 3.
- R2: While the counter is running, each rising edge of `tick_i` adds one to the 24-bit count. 0xFFFFFF wraps to 0. The new value is readable after the third rising clock edge that samples `tick_i` high.
- R3: A read of address 2 (top byte) with the snapshot released copies the live count into the snapshot and engages it. A read of address 2 with the snapshot engaged leaves the copy unchanged.
- R4: A read of address 1 (middle byte) returns the snapshot's middle byte while the snapshot is engaged, and has no side effect.
- R5: A read of address 0 (bottom byte) returns the snapshot's bottom byte if the snapshot is engaged, then releases it. With alarm-select set, a bottom-byte read never engages the snapshot. With the snapshot released, count reads return live bytes.
- R6: A count write to address 2 halts counting and a count write to address 0 resumes it. Neither write changes the snapshot or its engaged state.
- R7: A count write to address 1 replaces only the middle byte and has no other effect. A count write in the same cycle as a tick increment takes precedence, and that increment is lost.
- R8: Control register bit 0 (address 3) is alarm-select. While it is set, writes to addresses 0, 1 and 2 load the matching byte of the alarm register. The count and the run state stay untouched. A read of address 3 returns alarm-select in bit 0.
- R9: The alarm flag is set whenever the count equals the alarm after an increment, a count write or an alarm write. A read of address 4 returns the flag in bit 0 and then clears it, and a new match wins over the clear. `irq_o` equals the flag. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Asynchronous count event; rising edges count |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Alarm flag |

## Verification
Read data is combinational from the address, so a read returns its value in the cycle of the strobe. Its side effects (snapshot engage or release, flag clear) appear at the following edge. A tick counts at the third edge after it is first sampled high, and the alarm flag rises at the same edge as the update that matches. The bench drives inputs on the falling edge and samples one time unit later. It compares every cycle against a behavioural model that applies each update at the next rising edge. The directed checks wait out a full four-cycle tick pulse before reading.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic ctrl_wr;
    logic stat_rd;
    logic hi_rd;
    logic lo_rd;
  } tod_acc_t;
endpackage

// File: rtl/tod_tick_sync.sv
module tod_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tick_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tod_read_latch.sv
module tod_read_latch #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_rd_i,
  input  logic             lo_rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             latched_o,
  output logic [CNT_W-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latched_o <= 1'b0;
      snap_o    <= '0;
    end else if (lo_rd_i) begin
      latched_o <= 1'b0;
    end else if (hi_rd_i && !latched_o) begin
      latched_o <= 1'b1;
      snap_o    <= cnt_i;
    end
  end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
#(
  parameter int unsigned CNT_BYTES = 3,
  localparam int unsigned CNT_W    = CNT_BYTES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_BYTES-1:0] wr_lane_i,
  input  byte_t                wdata_i,
  input  logic [CNT_W-1:0]     cnt_next_i,
  input  logic                 cnt_upd_i,
  input  logic                 clr_i,
  output logic [CNT_W-1:0]     alarm_o,
  output logic                 flag_o
);
  logic [CNT_W-1:0] alarm_d;

  always_comb begin
    alarm_d = alarm_o;
    for (int g = 0; g < int'(CNT_BYTES); g++) begin
      if (wr_lane_i[g]) alarm_d[g*BYTE_W +: BYTE_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_o <= '1;
      flag_o  <= 1'b0;
    end else begin
      alarm_o <= alarm_d;
      if ((cnt_upd_i || (|wr_lane_i)) && (cnt_next_i == alarm_d)) flag_o <= 1'b1;
      else if (clr_i)                                             flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int unsigned CNT_BYTES   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = CNT_BYTES * BYTE_W,
  localparam int unsigned ADDR_W     = $clog2(CNT_BYTES + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int unsigned HI_IDX   = CNT_BYTES - 1;
  localparam int unsigned CTRL_IDX = CNT_BYTES;
  localparam int unsigned STAT_IDX = CNT_BYTES + 1;

  logic [CNT_BYTES-1:0] lane_hit, wr_lane, cnt_wr_lane, alm_wr_lane;
  tod_acc_t             acc;
  logic [CNT_W-1:0]     cnt_q, cnt_d, snap, alarm_q;
  logic                 run_q, started_q, sel_q, latched, tick_pulse, inc, cnt_upd, flag;

  // address decode
  for (genvar g = 0; g < int'(CNT_BYTES); g++) begin : g_lane
    assign lane_hit[g] = (addr_i == ADDR_W'(g));
  end

  assign wr_lane     = lane_hit & {CNT_BYTES{wr_en_i}};
  assign cnt_wr_lane = sel_q ? '0 : wr_lane;
  assign alm_wr_lane = sel_q ? wr_lane : '0;
  assign acc.hi_rd   = rd_en_i & lane_hit[HI_IDX];
  assign acc.lo_rd   = rd_en_i & lane_hit[0];
  assign acc.ctrl_wr = wr_en_i & (addr_i == ADDR_W'(CTRL_IDX));
  assign acc.stat_rd = rd_en_i & (addr_i == ADDR_W'(STAT_IDX));

  tod_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pulse_o(tick_pulse)
  );

  assign inc     = tick_pulse & run_q & started_q;
  assign cnt_upd = (|cnt_wr_lane) | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (|cnt_wr_lane) begin
      for (int g = 0; g < int'(CNT_BYTES); g++) begin
        if (cnt_wr_lane[g]) cnt_d[g*BYTE_W +: BYTE_W] = wdata_i;
      end
    end else if (inc) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      run_q     <= 1'b1;
      started_q <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (cnt_wr_lane[HI_IDX])  run_q <= 1'b0;
      else if (cnt_wr_lane[0])  run_q <= 1'b1;
      if ((|wr_lane) || acc.ctrl_wr) started_q <= 1'b1;
      if (acc.ctrl_wr) sel_q <= wdata_i[0];
    end
  end

  tod_read_latch #(.CNT_W(CNT_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hi_rd_i  (acc.hi_rd),
    .lo_rd_i  (acc.lo_rd),
    .cnt_i    (cnt_q),
    .latched_o(latched),
    .snap_o   (snap)
  );

  tod_alarm #(.CNT_BYTES(CNT_BYTES)) u_alarm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lane_i (alm_wr_lane),
    .wdata_i   (wdata_i),
    .cnt_next_i(cnt_d),
    .cnt_upd_i (cnt_upd),
    .clr_i     (acc.stat_rd),
    .alarm_o   (alarm_q),
    .flag_o    (flag)
  );

  assign irq_o = flag;

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < int'(CNT_BYTES); g++) begin
      if (lane_hit[g]) rdata_o = latched ? snap[g*BYTE_W +: BYTE_W] : cnt_q[g*BYTE_W +: BYTE_W];
    end
    if (addr_i == ADDR_W'(CTRL_IDX)) rdata_o = {7'b0, sel_q};
    if (addr_i == ADDR_W'(STAT_IDX)) rdata_o = {7'b0, flag};
  end
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int unsigned CNT_BYTES = 3,
  localparam int unsigned CNT_W    = CNT_BYTES * 8,
  localparam int unsigned ADDR_W   = $clog2(CNT_BYTES + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  alarm_q,
  input logic [CNT_W-1:0]  snap,
  input logic              latched,
  input logic              run_q,
  input logic              started_q,
  input logic              sel_q
);
  localparam logic [ADDR_W-1:0] A_LO = '0;
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(CNT_BYTES - 1);

  assert_idle_until_written_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!started_q && !wr_en_i) |=> $stable(cnt_q));

  assert_step_of_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_hi_read_engages_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_HI) |=> latched);

  assert_snapshot_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched && !(rd_en_i && addr_i == A_LO)) |=> (latched && $stable(snap)));

  assert_lo_read_releases_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_LO) |=> !latched);

  assert_hi_write_halts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_HI && !sel_q) |=> !run_q);

  assert_alarm_write_keeps_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i <= A_HI && sel_q) |=> $stable(run_q));

  assert_flag_on_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (cnt_q == alarm_q));
endmodule

bind tod_counter tod_counter_chk #(.CNT_BYTES(CNT_BYTES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .irq_o    (irq_o),
  .cnt_q    (cnt_q),
  .alarm_q  (alarm_q),
  .snap     (snap),
  .latched  (latched),
  .run_q    (run_q),
  .started_q(started_q),
  .sel_q    (sel_q)
);

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // behavioural reference state
  logic [23:0] m_cnt = '0, m_alarm = '1, m_snap = '0;
  bit m_latched = 0, m_run = 1, m_started = 0, m_sel = 0, m_flag = 0;
  bit tq[$] = '{0, 0, 0, 0};
  logic [7:0] got_rd;
  logic       got_irq;

  always #4 clk = ~clk;

  tod_counter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] model_rd(int a);
    if (a < 3) return m_latched ? m_snap[a*8 +: 8] : m_cnt[a*8 +: 8];
    if (a == 3) return {7'b0, m_sel};
    if (a == 4) return {7'b0, m_flag};
    return 8'h00;
  endfunction

  task automatic model_edge(bit w, bit r, int a, logic [7:0] d, bit t);
    logic [23:0] nc = m_cnt, na = m_alarm;
    bit inc, cw, aw;
    tq.push_back(t);
    inc = tq[tq.size()-3] && !tq[tq.size()-4] && m_run && m_started;
    if (tq.size() > 8) void'(tq.pop_front());
    cw = w && a < 3 && !m_sel;
    aw = w && a < 3 && m_sel;
    if (cw) nc[a*8 +: 8] = d;
    else if (inc) nc = nc + 24'd1;
    if (aw) na[a*8 +: 8] = d;
    if (cw && a == 2) m_run = 0;
    else if (cw && a == 0) m_run = 1;
    if (w && a <= 3) m_started = 1;
    if (w && a == 3) m_sel = d[0];
    if (r && a == 0) m_latched = 0;
    else if (r && a == 2 && !m_latched) begin m_latched = 1; m_snap = m_cnt; end
    if ((cw || inc || aw) && nc == na) m_flag = 1;
    else if (r && a == 4) m_flag = 0;
    m_cnt = nc;
    m_alarm = na;
  endtask

  task automatic step(bit w, bit r, int a, logic [7:0] d, bit t);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a[2:0]; wdata = d; tick = t;
    #1;
    got_rd = rdata; got_irq = irq;
    vectors++;
    if (got_rd !== model_rd(a) || got_irq !== m_flag) begin
      fails++;
      $display("FAIL MODEL addr=%0d: rdata=%h irq=%b, expected rdata=%h irq=%b",
               a, got_rd, got_irq, model_rd(a), m_flag);
    end
    model_edge(w, r, a, d, t);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(int a, logic [7:0] exp, string tag);
    step(0, 1, a, 8'h00, 0);
    chk(tag, got_rd, exp);
  endtask

  task automatic wr(int a, logic [7:0] d);
    step(1, 0, a, d, 0);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 7, 8'h00, 1);
      step(0, 0, 7, 8'h00, 1);
      step(0, 0, 7, 8'h00, 0);
      step(0, 0, 7, 8'h00, 0);
    end
  endtask

  task automatic irq_is(logic exp, string tag);
    step(0, 0, 7, 8'h00, 0);
    chk(tag, {7'b0, got_irq}, {7'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(0, 8'h00, "R1 count lo at reset");
    rd(4, 8'h00, "R1 flag at reset");
    irq_is(1'b0, "R1 irq at reset");
    pulse(3);
    rd(0, 8'h00, "R1 no count before first write");
    // start through control write
    wr(3, 8'h00);
    pulse(5);
    rd(0, 8'h05, "R2 five ticks counted");
    // load FFFFFE then wrap
    wr(2, 8'hFF); wr(1, 8'hFF); wr(0, 8'hFE);
    pulse(2);
    irq_is(1'b1, "R9 match at FFFFFF against reset alarm");
    rd(4, 8'h01, "R9 status shows flag");
    rd(4, 8'h00, "R9 status cleared by read");
    rd(2, 8'h00, "R2 wrap hi");
    rd(1, 8'h00, "R2 wrap mid");
    rd(0, 8'h00, "R2 wrap lo");
    // snapshot
    pulse(3);
    rd(2, 8'h00, "R3 hi read engages");
    pulse(2);
    rd(2, 8'h00, "R3 second hi read keeps copy");
    rd(1, 8'h00, "R4 mid from snapshot");
    rd(0, 8'h03, "R3 snapshot lo held while live advanced");
    rd(0, 8'h05, "R5 released, live lo");
    // halt / resume with snapshot engaged
    rd(2, 8'h00, "R3 engage at 000005");
    wr(2, 8'h01);
    rd(1, 8'h00, "R6 snapshot unchanged by hi write");
    rd(0, 8'h05, "R6 snapshot lo unchanged");
    rd(2, 8'h01, "R6 hi write loaded");
    rd(0, 8'h05, "R5 release");
    pulse(2);
    rd(0, 8'h05, "R6 halted after hi write");
    wr(0, 8'h07);
    pulse(1);
    rd(0, 8'h08, "R6 resumed after lo write");
    wr(1, 8'h20);
    rd(1, 8'h20, "R7 mid loaded");
    rd(0, 8'h08, "R7 lo untouched");
    rd(2, 8'h01, "R7 hi untouched");
    rd(0, 8'h08, "R5 release");
    // alarm select
    wr(3, 8'h01);
    rd(3, 8'h01, "R8 ctrl readback");
    wr(0, 8'h0A); wr(1, 8'h20); wr(2, 8'h01);
    rd(0, 8'h08, "R8 count not written");
    rd(2, 8'h01, "R8 count hi not written");
    rd(0, 8'h08, "R5 lo read with select set");
    pulse(1);
    rd(0, 8'h09, "R5 no snapshot engaged, R8 still running");
    irq_is(1'b0, "R9 no match yet");
    wr(3, 8'h00);
    pulse(1);
    irq_is(1'b1, "R9 match at alarm 01200A");
    rd(4, 8'h01, "R9 status read");
    irq_is(1'b0, "R9 cleared");
    rd(6, 8'h00, "R9 unused address reads zero");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule